// File: doc/BRIEF.md
# I2C Master Repeated-Start Generator

This block places a repeated START condition on an open-drain I2C bus for a master that has just finished transferring a byte. Software asks for the sequence by writing the control register with the request bit set. The block then walks SCL and SDA through the release, setup and hold phases. Each phase lasts one bit-time, which a 7-bit reload value sets. When the sequence finishes, the block holds both lines low so that the first bit of the next byte can follow.

Both lines are driven only as pull-low enables. They are read back through a two-flop synchronizer. A slave that holds SCL low stretches the phase in which SCL is being released. A line that does not follow what the block drives is reported as a bus collision, and the sequence then stops. While the sequence runs, writes to the transmit buffer and to the control register are refused. A write to the transmit buffer in that window raises a write-collision flag. The transmit buffer itself is a simple register that stands in for the byte data path.

Top module: `i2c_rstart_gen`

## Requirements
- R1: A control write with bit 1 (the repeated-start request) set starts the sequence only while the block is idle and `other_busy` is low. A control write made while `other_busy` is high leaves `ctl_q` unchanged and does not touch the bus. Requests are never queued.
- R2: On the clock edge that accepts the request, `ctl_q` bit 1 goes high, `scl_pull` goes high and `sda_pull` goes low.
- R3: One bit-time lasts `bit_reload`+1 clock cycles. With no stretching, counting the edge that samples the request as edge 0, `start_seen` rises at edge 11+2·`bit_reload` and `rs_done` rises at edge 12+3·`bit_reload`. These counts include the synchronizer delay.
- R4: After the SDA-release bit-time, SCL is released. The setup bit-time does not begin until SCL is sampled high, so a slave holding SCL low delays the whole sequence by as long as it holds the line.
- R5: `start_seen` is set when SDA is sampled falling while SCL is sampled high, after the block has pulled SDA low. At that moment `sda_pull` is high and `scl_pull` is low.
- R6: When the hold bit-time expires, `ctl_q` bit 1 clears, `scl_pull` goes high, `sda_pull` stays high and `rs_done` is set, all on the same edge.
- R7: A `txbuf_wr` while `ctl_q` bit 1 is high sets `wr_coll` one edge later and leaves `txbuf_q` unchanged. When the block is idle, `txbuf_wr` loads `txbuf_q` and leaves `wr_coll` unchanged.
- R8: While the sequence runs, control writes leave all five bits of `ctl_q` unchanged. When the block is idle and `other_busy` is low, a control write loads `ctl_q`.
- R9: A bus collision is flagged if SDA is sampled low at the moment SCL is first sampled high after the block released it.
- R10: A bus collision is flagged if SCL is sampled low during the setup bit-time, or before the falling edge of SDA is seen.
- R11: A collision releases both lines, clears `ctl_q` bit 1 and returns the block to idle. `bus_coll` stays set until it is cleared.
- R12: Reset clears all flags, `ctl_q` and `txbuf_q`, and releases both lines. Each bit of `flag_clr` clears one flag: bit 0 clears `start_seen`, bit 1 `rs_done`, bit 2 `wr_coll`, bit 3 `bus_coll`. A new event on the same edge takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_reload | input | 7 | Bit-time reload value (bit-time = value+1 cycles) |
| other_busy | input | 1 | Another bus event is in progress |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control write data; bit 1 is the repeated-start request |
| ctl_q | output | 5 | Control register contents |
| txbuf_wr | input | 1 | Transmit buffer write strobe |
| txbuf_wdata | input | 8 | Transmit buffer write data |
| txbuf_q | output | 8 | Transmit buffer contents |
| scl_in | input | 1 | SCL line as seen on the bus |
| sda_in | input | 1 | SDA line as seen on the bus |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| flag_clr | input | 4 | Per-flag clear strobes |
| start_seen | output | 1 | START pattern observed on the bus |
| rs_done | output | 1 | Repeated-start sequence complete |
| wr_coll | output | 1 | Transmit buffer written while busy |
| bus_coll | output | 1 | Bus collision detected |

## Verification
Every timing check counts rising edges from the edge that samples the request. On an undisturbed bus, `start_seen` is due at edge 11+2R and `rs_done` at edge 12+3R. The bench samples 1 ns after each edge and records the first edge on which each flag reads high, so an early or late result shows up as a wrong edge number. When SCL is stretched, the start flag is due at the release edge plus 7+R. Collision, write-collision and control-gating results appear one edge after the cause reaches the synchronizer output, and they are read a few edges later, once the outcome has settled.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  typedef enum logic [2:0] {
    RS_IDLE,
    RS_SCL_LO,
    RS_SDA_HI,
    RS_SCL_WAIT,
    RS_SETUP,
    RS_SDA_LO,
    RS_HOLD
  } rs_state_e;
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '1;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '1;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_rs_bitcnt.sv
module i2c_rs_bitcnt #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] reload,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= reload;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/i2c_rstart_gen.sv
module i2c_rstart_gen
  import i2c_rs_pkg::*;
#(
  parameter int RELOAD_W    = 7,
  parameter int CTL_W       = 5,
  parameter int REQ_BIT     = 1,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [RELOAD_W-1:0] bit_reload,
  input  logic                other_busy,
  input  logic                ctl_wr,
  input  logic [CTL_W-1:0]    ctl_wdata,
  output logic [CTL_W-1:0]    ctl_q,
  input  logic                txbuf_wr,
  input  logic [DATA_W-1:0]   txbuf_wdata,
  output logic [DATA_W-1:0]   txbuf_q,
  input  logic                scl_in,
  input  logic                sda_in,
  output logic                scl_pull,
  output logic                sda_pull,
  input  logic [3:0]          flag_clr,
  output logic                start_seen,
  output logic                rs_done,
  output logic                wr_coll,
  output logic                bus_coll
);
  localparam int LINES = 2;

  rs_state_e st, st_n;
  logic [LINES-1:0] line_s;
  logic scl_s, sda_s, scl_q, sda_q;
  logic cnt_load, cnt_run, cnt_zero;
  logic scl_n, sda_n, set_start, set_done, set_bcol, clr_req;
  logic idle, ctl_take, accept;

  i2c_rs_sync #(.W(LINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  i2c_rs_bitcnt #(.W(RELOAD_W)) cnt_i (
    .clk(clk), .rst(rst), .load(cnt_load), .run(cnt_run),
    .reload(bit_reload), .expired(cnt_zero)
  );

  assign idle     = (st == RS_IDLE);
  assign ctl_take = ctl_wr && idle && !other_busy;
  assign accept   = ctl_take && ctl_wdata[REQ_BIT];
  assign cnt_run  = (st == RS_SDA_HI) || (st == RS_SETUP) || (st == RS_HOLD);

  always_comb begin
    st_n      = st;
    scl_n     = scl_pull;
    sda_n     = sda_pull;
    cnt_load  = 1'b0;
    set_start = 1'b0;
    set_done  = 1'b0;
    set_bcol  = 1'b0;
    clr_req   = 1'b0;
    case (st)
      RS_IDLE: if (accept) begin
        st_n = RS_SCL_LO; scl_n = 1'b1; sda_n = 1'b0;
      end
      RS_SCL_LO: if (!scl_s) begin
        st_n = RS_SDA_HI; cnt_load = 1'b1;
      end
      RS_SDA_HI: if (cnt_zero && sda_s) begin
        st_n = RS_SCL_WAIT; scl_n = 1'b0;
      end
      RS_SCL_WAIT: if (scl_s) begin
        if (!sda_s && !scl_q) set_bcol = 1'b1;
        else begin st_n = RS_SETUP; cnt_load = 1'b1; end
      end
      RS_SETUP: begin
        if (!scl_s) set_bcol = 1'b1;
        else if (cnt_zero) begin st_n = RS_SDA_LO; sda_n = 1'b1; end
      end
      RS_SDA_LO: begin
        if (!scl_s) set_bcol = 1'b1;
        else if (!sda_s && sda_q) begin
          st_n = RS_HOLD; cnt_load = 1'b1; set_start = 1'b1;
        end
      end
      RS_HOLD: if (cnt_zero) begin
        st_n = RS_IDLE; scl_n = 1'b1; set_done = 1'b1; clr_req = 1'b1;
      end
      default: st_n = RS_IDLE;
    endcase
    if (set_bcol) begin
      st_n = RS_IDLE; scl_n = 1'b0; sda_n = 1'b0; clr_req = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= RS_IDLE;
      scl_pull   <= 1'b0;
      sda_pull   <= 1'b0;
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      ctl_q      <= '0;
      txbuf_q    <= '0;
      start_seen <= 1'b0;
      rs_done    <= 1'b0;
      wr_coll    <= 1'b0;
      bus_coll   <= 1'b0;
    end else begin
      st       <= st_n;
      scl_pull <= scl_n;
      sda_pull <= sda_n;
      scl_q    <= scl_s;
      sda_q    <= sda_s;
      if (ctl_take)     ctl_q <= ctl_wdata;
      else if (clr_req) ctl_q[REQ_BIT] <= 1'b0;
      if (txbuf_wr && idle) txbuf_q <= txbuf_wdata;
      if (set_start)        start_seen <= 1'b1;
      else if (flag_clr[0]) start_seen <= 1'b0;
      if (set_done)         rs_done <= 1'b1;
      else if (flag_clr[1]) rs_done <= 1'b0;
      if (txbuf_wr && !idle) wr_coll <= 1'b1;
      else if (flag_clr[2])  wr_coll <= 1'b0;
      if (set_bcol)         bus_coll <= 1'b1;
      else if (flag_clr[3]) bus_coll <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_rstart_chk.sv
module i2c_rstart_chk #(
  parameter int CTL_W   = 5,
  parameter int REQ_BIT = 1,
  parameter int DATA_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              other_busy,
  input logic              ctl_wr,
  input logic [CTL_W-1:0]  ctl_q,
  input logic              txbuf_wr,
  input logic [DATA_W-1:0] txbuf_q,
  input logic              scl_pull,
  input logic              sda_pull,
  input logic              start_seen,
  input logic              rs_done,
  input logic              wr_coll,
  input logic              bus_coll
);
  assert_busy_ignored_R1: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && other_busy && !ctl_q[REQ_BIT]) |=> !ctl_q[REQ_BIT]);

  assert_start_lines_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(start_seen) |-> (sda_pull && !scl_pull));

  assert_done_state_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(rs_done) |-> (scl_pull && sda_pull && !ctl_q[REQ_BIT]));

  assert_wcol_R7: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[REQ_BIT] && txbuf_wr) |=> (wr_coll && $stable(txbuf_q)));

  assert_ctl_locked_R8: assert property (@(posedge clk) disable iff (rst)
    ctl_q[REQ_BIT] |=> (!ctl_q[REQ_BIT] || $stable(ctl_q)));

  assert_coll_release_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_coll) |-> (!scl_pull && !sda_pull && !ctl_q[REQ_BIT]));
endmodule

bind i2c_rstart_gen i2c_rstart_chk #(.CTL_W(CTL_W), .REQ_BIT(REQ_BIT), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/i2c_rstart_gen_tb_top.sv
module i2c_rstart_gen_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] bit_reload = '0;
  logic other_busy = 1'b0;
  logic ctl_wr = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic [4:0] ctl_q;
  logic txbuf_wr = 1'b0;
  logic [7:0] txbuf_wdata = '0;
  logic [7:0] txbuf_q;
  logic scl_in, sda_in, scl_pull, sda_pull;
  logic slave_hold = 1'b0;
  logic sda_force = 1'b0;
  logic [3:0] flag_clr = '0;
  logic start_seen, rs_done, wr_coll, bus_coll;
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  assign scl_in = ~scl_pull & ~slave_hold;
  assign sda_in = ~sda_pull & ~sda_force;

  i2c_rstart_gen dut_i (
    .clk(clk), .rst(rst), .bit_reload(bit_reload), .other_busy(other_busy),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .txbuf_wr(txbuf_wr), .txbuf_wdata(txbuf_wdata), .txbuf_q(txbuf_q),
    .scl_in(scl_in), .sda_in(sda_in), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .flag_clr(flag_clr), .start_seen(start_seen), .rs_done(rs_done),
    .wr_coll(wr_coll), .bus_coll(bus_coll)
  );

  // {reload, start edge, done edge}
  localparam int VEC [5][3] = '{
    '{0, 11, 12}, '{1, 13, 15}, '{5, 21, 27}, '{17, 45, 63}, '{127, 265, 393}
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset();
    rst = 1'b1; slave_hold = 1'b0; sda_force = 1'b0; other_busy = 1'b0;
    tick(3);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic ctl_write(input logic [4:0] v);
    ctl_wdata = v; ctl_wr = 1'b1;
    tick(1);
    ctl_wr = 1'b0;
  endtask

  task automatic buf_write(input logic [7:0] v);
    txbuf_wdata = v; txbuf_wr = 1'b1;
    tick(1);
    txbuf_wr = 1'b0;
  endtask

  task automatic clear_flags(input logic [3:0] m);
    flag_clr = m;
    tick(1);
    flag_clr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int st_e, dn_e;
    // R12 reset state
    do_reset();
    check("R12 reset scl_pull", scl_pull, 0);
    check("R12 reset sda_pull", sda_pull, 0);
    check("R12 reset flags", {start_seen, rs_done, wr_coll, bus_coll}, 0);
    check("R12 reset ctl_q", ctl_q, 0);
    check("R12 reset txbuf_q", txbuf_q, 0);

    // R3 R5 R6 table of reload values
    for (int i = 0; i < 5; i++) begin
      do_reset();
      bit_reload = 7'(VEC[i][0]);
      ctl_write(5'b00010);
      if (i == 0) begin
        check("R2 scl pulled", scl_pull, 1);
        check("R2 sda released", sda_pull, 0);
        check("R2 request bit", ctl_q[1], 1);
      end
      st_e = -1; dn_e = -1;
      for (int k = 1; k < 600; k++) begin
        tick(1);
        if (start_seen && st_e < 0) st_e = k;
        if (rs_done && dn_e < 0) begin dn_e = k; break; end
      end
      check("R3/R5 start edge", st_e, VEC[i][1]);
      check("R3/R6 done edge", dn_e, VEC[i][2]);
      check("R6 lines held low", {scl_pull, sda_pull}, 2'b11);
      check("R6 request cleared", ctl_q[1], 0);
    end

    // R1 request while another event busy
    do_reset();
    other_busy = 1'b1;
    ctl_write(5'b00010);
    tick(6);
    check("R1 no bus action", scl_pull, 0);
    check("R1 ctl unchanged", ctl_q, 0);
    other_busy = 1'b0;

    // R7 R8 gating during the sequence, R12 clears
    do_reset();
    bit_reload = 7'd20;
    buf_write(8'hA5);
    check("R7 idle write loads", txbuf_q, 8'hA5);
    check("R7 idle write no wcol", wr_coll, 0);
    ctl_write(5'b00010);
    tick(2);
    buf_write(8'h3C);
    check("R7 busy write flagged", wr_coll, 1);
    check("R7 busy write dropped", txbuf_q, 8'hA5);
    ctl_write(5'b11101);
    check("R8 ctl locked", ctl_q, 5'b00010);
    for (int k = 0; k < 200 && !rs_done; k++) tick(1);
    check("R6 completion reached", rs_done, 1);
    clear_flags(4'b1111);
    check("R12 flags cleared", {start_seen, rs_done, wr_coll, bus_coll}, 0);
    ctl_write(5'b10001);
    check("R8 idle ctl write", ctl_q, 5'b10001);

    // R4 clock stretch
    do_reset();
    bit_reload = 7'd3;
    slave_hold = 1'b1;
    ctl_write(5'b00010);
    st_e = -1;
    for (int k = 1; k <= 40; k++) begin
      if (k > 1) tick(1);
      if (k == 20) begin
        check("R4 stalled no start", start_seen, 0);
        check("R4 stalled request held", ctl_q[1], 1);
        check("R4 scl released", scl_pull, 0);
        slave_hold = 1'b0;
      end
      if (start_seen && st_e < 0) st_e = k;
    end
    check("R4 start after stretch", st_e, 30);

    // R9 SDA low when SCL rises, R11 sticky and release
    do_reset();
    bit_reload = 7'd3;
    slave_hold = 1'b1;
    ctl_write(5'b00010);
    tick(12);
    sda_force = 1'b1;
    tick(3);
    slave_hold = 1'b0;
    tick(6);
    check("R9 collision flagged", bus_coll, 1);
    check("R11 lines released", {scl_pull, sda_pull}, 0);
    check("R11 request cleared", ctl_q[1], 0);
    sda_force = 1'b0;
    tick(5);
    check("R11 flag sticky", bus_coll, 1);
    clear_flags(4'b1000);
    check("R12 bus_coll cleared", bus_coll, 0);

    // R10 SCL low during setup
    do_reset();
    bit_reload = 7'd10;
    ctl_write(5'b00010);
    tick(18);
    slave_hold = 1'b1;
    tick(5);
    check("R10 collision flagged", bus_coll, 1);
    check("R10 no start", start_seen, 0);
    check("R11 request cleared", ctl_q[1], 0);
    slave_hold = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule